// File: doc/BRIEF.md
# Shared Video RAM Address Decoder

This block sits between an 8-bit processor with a multiplexed low address/data byte, a video generator and one static RAM that both of them use. It splits the 64K address space into four 16K segments with the two top address bits. It steers the RAM address either to the video side or to the processor, picks one of the 2K RAM devices, and produces the ROM select, a keyboard read strobe and a load strobe for the 6-bit video mode register that it contains.

Ownership of the RAM follows the processor clock phase and never stalls the processor. While E is low the video generator drives the RAM address, and the address strobe captures the low address byte from the multiplexed bus. While E is high a processor access to the RAM segment turns on the processor-side buffers. The RAM write strobe is further narrowed by an external write-window signal. Writes are blocked when address bit 12 is set, so the 4K RAM does not repeat its writes across the whole segment. An active-low external line, held high when nothing is connected, can suppress every device select.

All inputs are sampled on the rising edge of a fast system clock. Every output is a register that reflects the inputs of the previous edge.

Top module: `vram_decode`

## Requirements
- R1: Address bits 15:14 (`cpu_seg`) select the target. 0 selects nothing. 1 is RAM and raises `cpu_own`. 2 is the I/O segment (keyboard or mode register). 3 raises `rom_sel`.
- R2: Every select (`cpu_own`, `rom_sel`, `kbd_rd`, `mode_wr`, `ram_we`) is high only in the cycle after a clock edge at which `e_phase` was high.
- R3: When `ext_off_n` is sampled low, every select stays low and the mode register keeps its value.
- R4: When `cpu_own` is high, `ram_addr` is {address bits 11:8, latched low byte}. Otherwise `ram_addr` is the sampled `vid_addr`. `vid_off` always equals `cpu_own`.
- R5: `ram_cs` is one-hot. Bit 0 is set when `ram_addr[11]` is 0 and bit 1 is set when it is 1, so one device is always enabled.
- R6: `ram_we` is high only for a RAM-segment access with `cpu_rw`=0, `e_phase`=1, `wr_window`=1 and address bit 12 = 0.
- R7: In the I/O segment, `cpu_rw`=0 raises `mode_wr` and loads `mode_q` with `cpu_ad[5:0]` on the same edge. `cpu_rw`=1 raises `kbd_rd` and leaves `mode_q` unchanged. Bit layout of `mode_q`: [5] colour set, [4] alpha/graphics, [3:1] graphics mode, [0] internal/external font.
- R8: The low address byte is latched from `cpu_ad` at an edge where `e_phase`=0 and `addr_strobe`=1. At any other edge it holds.
- R9: After reset, `mode_q` is 0 (green alphanumeric), all selects are low, `ram_addr` is 0 and `ram_cs` is 2'b01.
- R10: At most one of `cpu_own`, `rom_sel`, `kbd_rd`, `mode_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_seg | input | 2 | Processor address bits 15:14 |
| cpu_amid | input | 5 | Processor address bits 12:8 |
| cpu_ad | input | 8 | Multiplexed low address / data byte |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| e_phase | input | 1 | Processor clock phase E |
| addr_strobe | input | 1 | Low-byte address strobe |
| ext_off_n | input | 1 | Active-low select suppress (pulled high) |
| wr_window | input | 1 | Write-window qualifier for the RAM write |
| vid_addr | input | 12 | Video generator RAM address |
| ram_addr | output | 12 | Address presented to the RAM devices |
| ram_cs | output | 2 | One-hot RAM device enable |
| ram_we | output | 1 | RAM write enable |
| cpu_own | output | 1 | Processor address/data buffers enabled |
| vid_off | output | 1 | Video address outputs disabled |
| rom_sel | output | 1 | ROM select |
| kbd_rd | output | 1 | Keyboard buffer read enable |
| mode_wr | output | 1 | Mode register load strobe |
| mode_q | output | 6 | Video mode register contents |

## Verification
Two things can happen at the same edge: the low-byte latch capturing a new byte, and the RAM address being steered to the video side. Both happen while E is low. The bench drives a cycle with E low and the strobe high together with a distinctive video address. It then checks that `ram_addr` shows only the video address and that no select fires. It then raises E for a RAM-segment access and checks that the address now carries the byte captured in the previous cycle. The rest of the decode is covered by a sweep over every combination of segment, bit 12, bit 11, R/W, E, window and suppress, with the expected outputs and mode-register value computed arithmetically.

// File: rtl/vram_dec_pkg.sv
package vram_dec_pkg;
  typedef enum logic [1:0] {
    SEG_NONE = 2'd0,
    SEG_RAM  = 2'd1,
    SEG_IO   = 2'd2,
    SEG_ROM  = 2'd3
  } seg_e;

  typedef struct packed {
    logic own;
    logic rom;
    logic kbd;
    logic mwr;
    logic we;
  } sel_t;
endpackage

// File: rtl/vram_seg_decode.sv
module vram_seg_decode
  import vram_dec_pkg::*;
(
  input  logic [1:0] seg,
  input  logic       rw,
  input  logic       e,
  input  logic       off_n,
  input  logic       win,
  input  logic       alias_bit,
  output sel_t       sel
);
  logic go;

  always_comb begin
    go  = e & off_n;
    sel = '0;
    unique case (seg_e'(seg))
      SEG_RAM: begin
        sel.own = go;
        sel.we  = go & ~rw & win & ~alias_bit;
      end
      SEG_IO: begin
        sel.kbd = go & rw;
        sel.mwr = go & ~rw;
      end
      SEG_ROM:  sel.rom = go;
      default:  sel = '0;
    endcase
  end
endmodule

// File: rtl/vram_lo_latch.sv
module vram_lo_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            e,
  input  logic            strobe,
  input  logic [LO_W-1:0] ad,
  output logic [LO_W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (rst)                 lat <= '0;
    else if (!e && strobe)   lat <= ad;
  end
endmodule

// File: rtl/vram_ram_steer.sv
module vram_ram_steer #(
  parameter int RAM_AW = 12,
  parameter int DEV_AW = 11,
  parameter int LO_W   = 8,
  localparam int MID_W = RAM_AW - LO_W,
  localparam int NDEV  = 1 << (RAM_AW - DEV_AW)
) (
  input  logic              own,
  input  logic [MID_W-1:0]  cpu_mid,
  input  logic [LO_W-1:0]   lat,
  input  logic [RAM_AW-1:0] vid,
  output logic [RAM_AW-1:0] addr,
  output logic [NDEV-1:0]   cs
);
  assign addr = own ? {cpu_mid, lat} : vid;

  for (genvar g = 0; g < NDEV; g++) begin : g_cs
    assign cs[g] = (addr[RAM_AW-1:DEV_AW] == (RAM_AW-DEV_AW)'(g));
  end
endmodule

// File: rtl/vram_mode_reg.sv
module vram_mode_reg #(
  parameter int MODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [MODE_W-1:0] d,
  output logic [MODE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/vram_decode.sv
module vram_decode
  import vram_dec_pkg::*;
#(
  parameter int LO_W   = 8,
  parameter int RAM_AW = 12,
  parameter int DEV_AW = 11,
  parameter int MODE_W = 6,
  localparam int MID_W = RAM_AW - LO_W,
  localparam int NDEV  = 1 << (RAM_AW - DEV_AW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_seg,
  input  logic [MID_W:0]    cpu_amid,
  input  logic [LO_W-1:0]   cpu_ad,
  input  logic              cpu_rw,
  input  logic              e_phase,
  input  logic              addr_strobe,
  input  logic              ext_off_n,
  input  logic              wr_window,
  input  logic [RAM_AW-1:0] vid_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [NDEV-1:0]   ram_cs,
  output logic              ram_we,
  output logic              cpu_own,
  output logic              vid_off,
  output logic              rom_sel,
  output logic              kbd_rd,
  output logic              mode_wr,
  output logic [MODE_W-1:0] mode_q
);
  sel_t              sel;
  logic [LO_W-1:0]   lat;
  logic [RAM_AW-1:0] addr_n;
  logic [NDEV-1:0]   cs_n;

  vram_seg_decode u_dec (
    .seg       (cpu_seg),
    .rw        (cpu_rw),
    .e         (e_phase),
    .off_n     (ext_off_n),
    .win       (wr_window),
    .alias_bit (cpu_amid[MID_W]),
    .sel       (sel)
  );

  vram_lo_latch #(.LO_W(LO_W)) u_lat (
    .clk    (clk),
    .rst    (rst),
    .e      (e_phase),
    .strobe (addr_strobe),
    .ad     (cpu_ad),
    .lat    (lat)
  );

  vram_ram_steer #(.RAM_AW(RAM_AW), .DEV_AW(DEV_AW), .LO_W(LO_W)) u_steer (
    .own     (sel.own),
    .cpu_mid (cpu_amid[MID_W-1:0]),
    .lat     (lat),
    .vid     (vid_addr),
    .addr    (addr_n),
    .cs      (cs_n)
  );

  vram_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk (clk),
    .rst (rst),
    .ld  (sel.mwr),
    .d   (cpu_ad[MODE_W-1:0]),
    .q   (mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_cs   <= NDEV'(1);
      ram_we   <= 1'b0;
      cpu_own  <= 1'b0;
      vid_off  <= 1'b0;
      rom_sel  <= 1'b0;
      kbd_rd   <= 1'b0;
      mode_wr  <= 1'b0;
    end else begin
      ram_addr <= addr_n;
      ram_cs   <= cs_n;
      ram_we   <= sel.we;
      cpu_own  <= sel.own;
      vid_off  <= sel.own;
      rom_sel  <= sel.rom;
      kbd_rd   <= sel.kbd;
      mode_wr  <= sel.mwr;
    end
  end
endmodule

// File: rtl/vram_decode_chk.sv
module vram_decode_chk #(
  parameter int LO_W   = 8,
  parameter int RAM_AW = 12,
  parameter int MODE_W = 6,
  parameter int NDEV   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [LO_W-1:0]   cpu_ad,
  input logic              cpu_rw,
  input logic              e_phase,
  input logic              ext_off_n,
  input logic              wr_window,
  input logic [RAM_AW-1:0] vid_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [NDEV-1:0]   ram_cs,
  input logic              ram_we,
  input logic              cpu_own,
  input logic              rom_sel,
  input logic              kbd_rd,
  input logic              mode_wr,
  input logic [MODE_W-1:0] mode_q
);
  p_one_sel_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_own, rom_sel, kbd_rd, mode_wr}));

  p_e_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(e_phase) |-> !(cpu_own || rom_sel || kbd_rd || mode_wr || ram_we));

  p_suppress_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_off_n) |-> !(cpu_own || rom_sel || kbd_rd || mode_wr || ram_we));

  p_we_win_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (cpu_own && $past(wr_window) && !$past(cpu_rw)));

  p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot(ram_cs));

  p_vid_path_r4: assert property (@(posedge clk) disable iff (rst)
    !cpu_own |-> (ram_addr == $past(vid_addr)));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |-> $stable(mode_q));

  p_mode_load_r7: assert property (@(posedge clk) disable iff (rst)
    mode_wr |-> (mode_q == $past(cpu_ad[MODE_W-1:0])));
endmodule

bind vram_decode vram_decode_chk #(
  .LO_W(LO_W), .RAM_AW(RAM_AW), .MODE_W(MODE_W), .NDEV(NDEV)
) u_chk (
  .clk(clk), .rst(rst), .cpu_ad(cpu_ad), .cpu_rw(cpu_rw),
  .e_phase(e_phase), .ext_off_n(ext_off_n), .wr_window(wr_window),
  .vid_addr(vid_addr), .ram_addr(ram_addr), .ram_cs(ram_cs),
  .ram_we(ram_we), .cpu_own(cpu_own), .rom_sel(rom_sel),
  .kbd_rd(kbd_rd), .mode_wr(mode_wr), .mode_q(mode_q)
);

// File: tb/vram_decode_test.sv
module vram_decode_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cpu_seg;
  logic [4:0]  cpu_amid;
  logic [7:0]  cpu_ad;
  logic        cpu_rw, e_phase, addr_strobe, ext_off_n, wr_window;
  logic [11:0] vid_addr;
  logic [11:0] ram_addr;
  logic [1:0]  ram_cs;
  logic        ram_we, cpu_own, vid_off, rom_sel, kbd_rd, mode_wr;
  logic [5:0]  mode_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  vram_decode uut (
    .clk(clk), .rst(rst), .cpu_seg(cpu_seg), .cpu_amid(cpu_amid),
    .cpu_ad(cpu_ad), .cpu_rw(cpu_rw), .e_phase(e_phase),
    .addr_strobe(addr_strobe), .ext_off_n(ext_off_n), .wr_window(wr_window),
    .vid_addr(vid_addr), .ram_addr(ram_addr), .ram_cs(ram_cs),
    .ram_we(ram_we), .cpu_own(cpu_own), .vid_off(vid_off),
    .rom_sel(rom_sel), .kbd_rd(kbd_rd), .mode_wr(mode_wr), .mode_q(mode_q)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  lat_exp;
    logic [5:0]  mode_exp;
    rst = 1'b1;
    cpu_seg = 2'd0; cpu_amid = '0; cpu_ad = '0; cpu_rw = 1'b1;
    e_phase = 1'b0; addr_strobe = 1'b0; ext_off_n = 1'b1; wr_window = 1'b0;
    vid_addr = 12'h000;
    tick(); tick();
    // R9: reset state
    chk("R9", "mode_q", mode_q, 0);
    chk("R9", "selects", {cpu_own, rom_sel, kbd_rd, mode_wr, ram_we}, 0);
    chk("R9", "ram_addr", ram_addr, 0);
    chk("R9", "ram_cs", ram_cs, 2'b01);
    rst = 1'b0;

    // R8: capture low byte during E low with strobe
    e_phase = 1'b0; addr_strobe = 1'b1; cpu_ad = 8'hC3; vid_addr = 12'h321;
    tick();
    chk("R4", "video addr during E low", ram_addr, 12'h321);
    addr_strobe = 1'b0; cpu_ad = 8'h11;
    tick();  // no capture: strobe low
    e_phase = 1'b1; cpu_seg = 2'd1; cpu_amid = 5'b01010; cpu_rw = 1'b1;
    tick();
    chk("R8", "latched byte held", ram_addr, 12'hAC3);
    chk("R5", "cs for bit11=1", ram_cs, 2'b10);
    chk("R1", "ram segment own", cpu_own, 1);
    chk("R4", "vid_off follows own", vid_off, 1);

    // Coincidence: latch capture and video steering in the same cycle
    e_phase = 1'b0; addr_strobe = 1'b1; cpu_ad = 8'h7E; vid_addr = 12'hABC;
    tick();
    chk("R4", "video addr while latching", ram_addr, 12'hABC);
    chk("R2", "no select while latching", {cpu_own, rom_sel, kbd_rd, mode_wr, ram_we}, 0);
    addr_strobe = 1'b0; e_phase = 1'b1; cpu_seg = 2'd1; cpu_amid = 5'b00101;
    cpu_ad = 8'h00;
    tick();
    chk("R8", "new byte after capture", ram_addr, 12'h57E);
    chk("R5", "cs for bit11=0", ram_cs, 2'b01);
    lat_exp = 8'h7E;
    mode_exp = 6'd0;

    // Exhaustive sweep over decode inputs
    for (int i = 0; i < 256; i++) begin
      logic [1:0]  sg;
      logic        a12, a11, rw, e, win, on;
      logic        own, rom, kbd, mw, we;
      logic [11:0] va, ea;
      logic [7:0]  d;
      sg = i[1:0]; a12 = i[2]; a11 = i[3]; rw = i[4];
      e = i[5]; win = i[6]; on = i[7];
      va = 12'((i * 37) ^ 12'h9A5);
      d  = 8'(i) ^ 8'h5A;
      cpu_seg = sg; cpu_amid = {a12, a11, 3'b101}; cpu_rw = rw;
      e_phase = e; wr_window = win; ext_off_n = on; addr_strobe = 1'b0;
      vid_addr = va; cpu_ad = d;
      tick();
      own = e & on & (sg == 2'd1);
      rom = e & on & (sg == 2'd3);
      kbd = e & on & (sg == 2'd2) & rw;
      mw  = e & on & (sg == 2'd2) & ~rw;
      we  = own & ~rw & win & ~a12;
      if (mw) mode_exp = d[5:0];
      ea  = own ? {a11, 3'b101, lat_exp} : va;
      // R1 R2 R3 R6 R7 R10 combined decode check
      chk("R1/R2/R3/R10", "selects", {cpu_own, rom_sel, kbd_rd, mode_wr},
          {own, rom, kbd, mw});
      chk("R6", "ram_we", ram_we, we);
      chk("R4", "ram_addr", ram_addr, ea);
      chk("R5", "ram_cs", ram_cs, ea[11] ? 2'b10 : 2'b01);
      chk("R7", "mode_q", mode_q, mode_exp);
    end

    // R3: suppressed mode write leaves register
    cpu_seg = 2'd2; cpu_rw = 1'b0; e_phase = 1'b1; ext_off_n = 1'b0;
    cpu_ad = ~{2'b00, mode_exp};
    tick();
    chk("R3", "mode kept under suppress", mode_q, mode_exp);
    // R7: keyboard read leaves mode register
    ext_off_n = 1'b1; cpu_rw = 1'b1;
    tick();
    chk("R7", "kbd read", kbd_rd, 1);
    chk("R7", "mode kept on read", mode_q, mode_exp);
    // R6: window low blocks write
    cpu_seg = 2'd1; cpu_amid = 5'b00000; cpu_rw = 1'b0; wr_window = 1'b0;
    tick();
    chk("R6", "no we without window", ram_we, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule